// File: doc/BRIEF.md
# DMA Setup Register File

This block holds the processor-visible state that programs a DMA transfer: a 16-bit count and control word and a 22-bit word-aligned memory address. A processor writes and reads it over a simple register bus. The count register carries the transfer count, the direction and the enable. The address register is unusual because its value is taken from the address lines of the write, not from the data bus. Bus address bit 14 picks which half of the address is loaded. The data bus is ignored for address writes.

A transfer engine outside the block reads the current address, count, direction and enable from the outputs. It pulses `xfer_done` once per completed word, and the block counts the pulse. A count write with the direction bit clear makes the block run one dummy transfer cycle. A small state machine handles this. It has two states, `ST_IDLE` and `ST_DUMMY`. The move from `ST_IDLE` to `ST_DUMMY` (named *arm*) happens on a count write with the direction bit clear. The move from `ST_DUMMY` back to `ST_IDLE` (named *bump*) is unconditional and adds one to the count. If a count write with the direction bit clear lands while the machine is in `ST_DUMMY`, the machine stays in `ST_DUMMY` (named *rearm*). While the machine is in `ST_DUMMY`, the output `dummy_req` is high for that single cycle.

Top module: `dma_setup_regs`

## Requirements
- R1: A 16-bit count write (bus_sel=1, bus_wr=1, bus_wide=1, bus_addr[19:16]=4'h6) stores bus_wdata[13:0] as dma_count, bus_wdata[14] as dma_dir and bus_wdata[15] as dma_en. All three outputs show the new values after that clock edge.
- R2: A read (bus_rd=1) of the count register loads bus_rdata with {2'b11, dma_count} at the edge. A read of any other selection loads 16'hFFFF.
- R3: A count write with bus_wdata[14]=0 raises dummy_req for exactly the next cycle. At the end of that cycle, dma_count increases by one.
- R4: An address write (bus_addr[19:16]=4'hD) with bus_addr[14]=1 loads dma_addr[21:9] from bus_addr[13:1]. It leaves dma_addr[8:0] unchanged.
- R5: An address write with bus_addr[14]=0 loads dma_addr[8:1] from bus_addr[8:1]. It leaves dma_addr[21:9] unchanged.
- R6: dma_addr[0] is always zero, and bus_addr[0] has no effect on it.
- R7: A count write with bus_wide=0 changes none of dma_count, dma_dir, dma_en and does not raise dummy_req.
- R8: Each xfer_done pulse in `ST_IDLE`, without a count write in the same cycle, adds one to dma_count. The count wraps from 14'h3FFF to 0.
- R9: A count write takes priority over xfer_done in the same cycle. An xfer_done during `ST_DUMMY` adds nothing beyond the dummy increment.
- R10: After reset, dma_count=0, dma_dir=0, dma_en=0, dma_addr=0, dummy_req=0 and bus_rdata=16'hFFFF.
- R11: A write with bus_sel=0, or with bus_addr[19:16] that matches neither register, changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Block select for the register bus |
| bus_addr | input | 24 | Bus address; bits [19:16] pick the register; bits [14:1] carry address-register data |
| bus_wdata | input | 16 | Write data for the count register |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wide | input | 1 | 1 for a 16-bit access, 0 for a byte access |
| bus_rdata | output | 16 | Registered read data |
| xfer_done | input | 1 | One pulse per word moved by the transfer engine |
| dma_addr | output | 22 | Current DMA byte address, always even |
| dma_count | output | 14 | Current transfer count |
| dma_dir | output | 1 | Transfer direction bit |
| dma_en | output | 1 | DMA enable |
| dummy_req | output | 1 | One-cycle request for the dummy transfer |

## Verification
A register write or an `xfer_done` pulse changes the outputs one clock edge after the cycle that presents it. bus_rdata is likewise due one edge after the read strobe. The dummy request is high in the cycle that follows the arming write, and the extra count increment appears one edge later. The bench drives inputs and samples outputs on the falling edge. Each result is therefore read half a cycle after the rising edge that produced it, and the dummy sequence is checked on two consecutive falling edges.

// File: rtl/dmareg_pkg.sv
package dmareg_pkg;

    // Phase of the dummy-transfer sequencer
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_DUMMY = 1'b1
    } dma_phase_e;

    // Register selection result of the bus decoder
    typedef struct packed {
        logic cnt_hit;
        logic adr_hit;
    } reg_hit_t;

endpackage

// File: rtl/dmareg_decode.sv
module dmareg_decode
    import dmareg_pkg::*;
#(
    parameter int PAGE_W   = 4,
    parameter int CNT_PAGE = 6,
    parameter int ADR_PAGE = 13
) (
    input  logic              sel,
    input  logic [PAGE_W-1:0] page,
    output reg_hit_t          hit
);

    localparam logic [PAGE_W-1:0] CNT_CODE = PAGE_W'(CNT_PAGE);
    localparam logic [PAGE_W-1:0] ADR_CODE = PAGE_W'(ADR_PAGE);

    always_comb begin
        hit.cnt_hit = sel && (page == CNT_CODE);
        hit.adr_hit = sel && (page == ADR_CODE);
    end

endmodule

// File: rtl/dmareg_count.sv
module dmareg_count
    import dmareg_pkg::*;
#(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_cnt,
    input  logic [CNT_W+1:0] wdata,
    input  logic             xfer_done,
    output logic [CNT_W-1:0] count,
    output logic             dir,
    output logic             en,
    output logic             dummy_req
);

    localparam int DIR_BIT = CNT_W;
    localparam int EN_BIT  = CNT_W + 1;

    dma_phase_e phase_q, phase_nx;

    // Writing with the direction bit clear arms the dummy cycle
    logic arm;
    assign arm = wr_cnt && !wdata[DIR_BIT];

    // Next-state logic
    always_comb begin
        phase_nx = phase_q;
        unique case (phase_q)
            ST_IDLE:  phase_nx = arm ? ST_DUMMY : ST_IDLE;
            ST_DUMMY: phase_nx = arm ? ST_DUMMY : ST_IDLE;
            default:  phase_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= ST_IDLE;
        else        phase_q <= phase_nx;
    end

    // Outputs decoded from state
    always_comb begin
        dummy_req = 1'b0;
        unique case (phase_q)
            ST_IDLE:  dummy_req = 1'b0;
            ST_DUMMY: dummy_req = 1'b1;
            default:  dummy_req = 1'b0;
        endcase
    end

    // Count and control storage: write > dummy bump > transfer done
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
            dir   <= 1'b0;
            en    <= 1'b0;
        end else if (wr_cnt) begin
            count <= wdata[CNT_W-1:0];
            dir   <= wdata[DIR_BIT];
            en    <= wdata[EN_BIT];
        end else if (phase_q == ST_DUMMY) begin
            count <= count + 1'b1;
        end else if (xfer_done) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/dmareg_addr.sv
module dmareg_addr #(
    parameter int AW      = 22,
    parameter int LO_TOP  = 8,
    parameter int SEL_BIT = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_adr,
    input  logic [SEL_BIT:1] src,
    output logic [AW-1:0]    dma_addr
);

    localparam int HI_W = AW - 1 - LO_TOP;
    localparam int LO_W = LO_TOP;

    logic [HI_W-1:0] hi_q;
    logic [LO_W-1:0] lo_q;

    // Upper half loads when the select line is high
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     hi_q <= '0;
        else if (wr_adr && src[SEL_BIT]) hi_q <= src[HI_W:1];
    end

    // Lower half loads when the select line is low
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       lo_q <= '0;
        else if (wr_adr && !src[SEL_BIT]) lo_q <= src[LO_TOP:1];
    end

    // Word aligned: byte bit 0 is always zero
    assign dma_addr = {hi_q, lo_q, 1'b0};

    logic unused_src;
    assign unused_src = ^src[SEL_BIT-1:HI_W+1];

endmodule

// File: rtl/dma_setup_regs.sv
module dma_setup_regs
    import dmareg_pkg::*;
#(
    parameter int CNT_W    = 14,
    parameter int AW       = 22,
    parameter int BUS_AW   = 24,
    parameter int PAGE_LSB = 16,
    parameter int PAGE_W   = 4,
    parameter int CNT_PAGE = 6,
    parameter int ADR_PAGE = 13,
    parameter int SEL_BIT  = 14,
    parameter int LO_TOP   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [CNT_W+1:0]  bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              bus_wide,
    output logic [CNT_W+1:0]  bus_rdata,
    input  logic              xfer_done,
    output logic [AW-1:0]     dma_addr,
    output logic [CNT_W-1:0]  dma_count,
    output logic              dma_dir,
    output logic              dma_en,
    output logic              dummy_req
);

    localparam int DW = CNT_W + 2;

    reg_hit_t hit;

    dmareg_decode #(
        .PAGE_W  (PAGE_W),
        .CNT_PAGE(CNT_PAGE),
        .ADR_PAGE(ADR_PAGE)
    ) u_decode (
        .sel (bus_sel),
        .page(bus_addr[PAGE_LSB+PAGE_W-1:PAGE_LSB]),
        .hit (hit)
    );

    // Count register accepts only full-width writes
    logic wr_cnt, wr_adr;
    assign wr_cnt = bus_wr && hit.cnt_hit && bus_wide;
    assign wr_adr = bus_wr && hit.adr_hit;

    dmareg_count #(
        .CNT_W(CNT_W)
    ) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_cnt   (wr_cnt),
        .wdata    (bus_wdata),
        .xfer_done(xfer_done),
        .count    (dma_count),
        .dir      (dma_dir),
        .en       (dma_en),
        .dummy_req(dummy_req)
    );

    dmareg_addr #(
        .AW     (AW),
        .LO_TOP (LO_TOP),
        .SEL_BIT(SEL_BIT)
    ) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_adr  (wr_adr),
        .src     (bus_addr[SEL_BIT:1]),
        .dma_addr(dma_addr)
    );

    // Registered read port; upper two count bits read as ones
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '1;
        end else if (bus_rd) begin
            if (hit.cnt_hit) bus_rdata <= {2'b11, dma_count};
            else             bus_rdata <= {DW{1'b1}};
        end
    end

    logic unused_addr;
    assign unused_addr = ^{bus_addr[BUS_AW-1:PAGE_LSB+PAGE_W],
                           bus_addr[PAGE_LSB-1:SEL_BIT+1],
                           bus_addr[0]};

endmodule

// File: rtl/dma_setup_regs_chk.sv
module dma_setup_regs_chk #(
    parameter int CNT_W    = 14,
    parameter int AW       = 22,
    parameter int BUS_AW   = 24,
    parameter int PAGE_LSB = 16,
    parameter int PAGE_W   = 4,
    parameter int CNT_PAGE = 6,
    parameter int ADR_PAGE = 13,
    parameter int SEL_BIT  = 14,
    parameter int LO_TOP   = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic [BUS_AW-1:0] bus_addr,
    input logic [CNT_W+1:0]  bus_wdata,
    input logic              bus_wr,
    input logic              bus_wide,
    input logic              xfer_done,
    input logic [AW-1:0]     dma_addr,
    input logic [CNT_W-1:0]  dma_count,
    input logic              dma_dir,
    input logic              dma_en,
    input logic              dummy_req
);

    logic [PAGE_W-1:0] page;
    logic cnt_any, cnt_wr, cnt_narrow, adr_wr;
    assign page       = bus_addr[PAGE_LSB+PAGE_W-1:PAGE_LSB];
    assign cnt_any    = bus_sel && bus_wr && (page == PAGE_W'(CNT_PAGE));
    assign cnt_wr     = cnt_any && bus_wide;
    assign cnt_narrow = cnt_any && !bus_wide;
    assign adr_wr     = bus_sel && bus_wr && (page == PAGE_W'(ADR_PAGE));

    // R1
    cnt_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (dma_count == $past(bus_wdata[CNT_W-1:0])) &&
                   (dma_dir == $past(bus_wdata[CNT_W])) &&
                   (dma_en == $past(bus_wdata[CNT_W+1])));

    // R3
    dummy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_wr && !bus_wdata[CNT_W]) |=> dummy_req);

    // R3
    dummy_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dummy_req && !cnt_wr) |=> (!dummy_req &&
            (dma_count == CNT_W'($past(dma_count) + 1'b1))));

    // R4
    addr_hi_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adr_wr && bus_addr[SEL_BIT]) |=>
            (dma_addr[LO_TOP:0] == $past(dma_addr[LO_TOP:0])));

    // R5
    addr_lo_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adr_wr && !bus_addr[SEL_BIT]) |=>
            (dma_addr[AW-1:LO_TOP+1] == $past(dma_addr[AW-1:LO_TOP+1])));

    // R8
    done_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && !cnt_wr && !dummy_req) |=>
            (dma_count == CNT_W'($past(dma_count) + 1'b1)));

    // R7
    narrow_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_narrow && !dummy_req && !xfer_done) |=>
            ($stable(dma_count) && $stable(dma_dir) && $stable(dma_en) && !dummy_req));

endmodule

bind dma_setup_regs dma_setup_regs_chk #(
    .CNT_W   (CNT_W),
    .AW      (AW),
    .BUS_AW  (BUS_AW),
    .PAGE_LSB(PAGE_LSB),
    .PAGE_W  (PAGE_W),
    .CNT_PAGE(CNT_PAGE),
    .ADR_PAGE(ADR_PAGE),
    .SEL_BIT (SEL_BIT),
    .LO_TOP  (LO_TOP)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_wr   (bus_wr),
    .bus_wide (bus_wide),
    .xfer_done(xfer_done),
    .dma_addr (dma_addr),
    .dma_count(dma_count),
    .dma_dir  (dma_dir),
    .dma_en   (dma_en),
    .dummy_req(dummy_req)
);

// File: tb/tb_dma_setup_regs.sv
`timescale 1ns/1ps
module tb_dma_setup_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic [23:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic        bus_wide = 1'b1;
    logic [15:0] bus_rdata;
    logic        xfer_done = 1'b0;
    logic [21:0] dma_addr;
    logic [13:0] dma_count;
    logic        dma_dir, dma_en, dummy_req;

    always #2.5 clk = ~clk;

    dma_setup_regs dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wide(bus_wide), .bus_rdata(bus_rdata), .xfer_done(xfer_done),
        .dma_addr(dma_addr), .dma_count(dma_count), .dma_dir(dma_dir),
        .dma_en(dma_en), .dummy_req(dummy_req)
    );

    localparam logic [23:0] CNT_BASE = 24'h060000;
    localparam logic [23:0] ADR_BASE = 24'h0D0000;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic sel, input logic [23:0] a, input logic [15:0] d,
                            input logic wide, input logic done);
        @(negedge clk);
        bus_sel = sel; bus_addr = a; bus_wdata = d; bus_wide = wide;
        bus_wr = 1'b1; xfer_done = done;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wide = 1'b1; xfer_done = 1'b0;
    endtask

    task automatic do_read(input logic [23:0] a);
        @(negedge clk);
        bus_sel = 1'b1; bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_sel = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk);
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
    endtask

    // {is_cnt, offset[15:0], data[15:0], exp_cnt[13:0], exp_dir, exp_en, exp_addr[21:0]}
    localparam int NV = 9;
    localparam logic [70:0] VEC [NV] = '{
        {1'b0, 16'h01FE, 16'hFFFF, 14'h0000, 1'b0, 1'b0, 22'h0001FE},
        {1'b1, 16'h0000, 16'hD234, 14'h1234, 1'b1, 1'b1, 22'h0001FE},
        {1'b0, 16'h7FFE, 16'h0000, 14'h1234, 1'b1, 1'b1, 22'h3FFFFE},
        {1'b0, 16'h0000, 16'h1234, 14'h1234, 1'b1, 1'b1, 22'h3FFE00},
        {1'b1, 16'h0000, 16'h7FFF, 14'h3FFF, 1'b1, 1'b0, 22'h3FFE00},
        {1'b0, 16'h4002, 16'hAAAA, 14'h3FFF, 1'b1, 1'b0, 22'h000200},
        {1'b0, 16'h3AB5, 16'h5555, 14'h3FFF, 1'b1, 1'b0, 22'h0002B4},
        {1'b1, 16'h0000, 16'h4000, 14'h0000, 1'b1, 1'b0, 22'h0002B4},
        {1'b0, 16'h6469, 16'hFFFF, 14'h0000, 1'b1, 1'b0, 22'h2468B4}
    };

    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset values
        check("R10 count", 32'(dma_count), 32'h0);
        check("R10 dir/en", {30'h0, dma_dir, dma_en}, 32'h0);
        check("R10 addr", 32'(dma_addr), 32'h0);
        check("R10 dummy", 32'(dummy_req), 32'h0);
        check("R10 rdata", 32'(bus_rdata), 32'hFFFF);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R1 R2 R4 R5 R6
        for (int i = 0; i < NV; i++) begin
            logic [70:0] v;
            v = VEC[i];
            do_write(1'b1, (v[70] ? CNT_BASE : ADR_BASE) | {8'h0, v[69:54]}, v[53:38], 1'b1, 1'b0);
            check("R1 count", 32'(dma_count), 32'(v[37:24]));
            check("R1 dir", 32'(dma_dir), 32'(v[23]));
            check("R1 en", 32'(dma_en), 32'(v[22]));
            check("R4/R5 addr", 32'(dma_addr), 32'(v[21:0]));
            check("R6 addr bit0", 32'(dma_addr[0]), 32'h0);
            check("R3 no dummy when dir set", 32'(dummy_req), 32'h0);
            do_read(CNT_BASE);
            check("R2 count readback", 32'(bus_rdata), {16'h0, 2'b11, v[37:24]});
        end

        // R2 other register reads as all ones
        do_read(ADR_BASE);
        check("R2 other read", 32'(bus_rdata), 32'hFFFF);

        // R7 narrow write ignored
        do_write(1'b1, CNT_BASE, 16'h0123, 1'b0, 1'b0);
        check("R7 count", 32'(dma_count), 32'h0);
        check("R7 dir/en", {30'h0, dma_dir, dma_en}, 32'h2);
        check("R7 dummy", 32'(dummy_req), 32'h0);

        // R11 unselected or unmatched writes ignored
        do_write(1'b0, CNT_BASE, 16'h8055, 1'b1, 1'b0);
        check("R11 sel low count", 32'(dma_count), 32'h0);
        check("R11 sel low en", 32'(dma_en), 32'h0);
        do_write(1'b1, 24'h050000, 16'h8055, 1'b1, 1'b0);
        check("R11 other page count", 32'(dma_count), 32'h0);
        do_write(1'b0, ADR_BASE | 24'h00FE, 16'h0, 1'b1, 1'b0);
        check("R11 sel low addr", 32'(dma_addr), 32'h2468B4);

        // R3 dummy sequence
        do_write(1'b1, CNT_BASE, 16'h8010, 1'b1, 1'b0);
        check("R3 dummy high", 32'(dummy_req), 32'h1);
        check("R3 count loaded", 32'(dma_count), 32'h10);
        check("R1 en/dir", {30'h0, dma_dir, dma_en}, 32'h1);
        @(negedge clk);
        check("R3 dummy low", 32'(dummy_req), 32'h0);
        check("R3 count bumped", 32'(dma_count), 32'h11);

        // R8 transfer-done increments
        for (int k = 0; k < 3; k++) pulse_done();
        check("R8 three pulses", 32'(dma_count), 32'h14);
        do_write(1'b1, CNT_BASE, 16'h7FFF, 1'b1, 1'b0);
        pulse_done();
        check("R8 wrap", 32'(dma_count), 32'h0);
        check("R8 dir kept", 32'(dma_dir), 32'h1);

        // R9 write beats done
        do_write(1'b1, CNT_BASE, 16'h4005, 1'b1, 1'b1);
        check("R9 write priority", 32'(dma_count), 32'h5);

        // R9 done during dummy cycle adds nothing extra
        @(negedge clk);
        bus_sel = 1'b1; bus_addr = CNT_BASE; bus_wdata = 16'h0020;
        bus_wide = 1'b1; bus_wr = 1'b1; xfer_done = 1'b1;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        check("R9 dummy with done", 32'(dummy_req), 32'h1);
        @(negedge clk);
        xfer_done = 1'b0;
        check("R9 single bump", 32'(dma_count), 32'h21);

        // R10 reset in mid-operation
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 re-reset count", 32'(dma_count), 32'h0);
        check("R10 re-reset addr", 32'(dma_addr), 32'h0);
        rst_n = 1'b1;

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule